// File: doc/BRIEF.md
# Daisy-Chained Interrupt Requester

This block is the requesting side of a prioritized, level-based interrupt scheme on a shared backplane. A local event pulse raises a pending request, which the block shows as an active-low request line at one fixed level. A handler later runs an acknowledge cycle. It places the level it is serving on three low address bits, lowers one or both data strobes and, where needed, the long-word line. The acknowledge then ripples down a chain of boards as a falling edge. All backplane inputs reach this block already synchronised to `clk`.

On a falling edge of its chain input, the block takes one decision. It claims the cycle when a request was pending at that instant, the address level equals its own, and the requested width is at least its own status/ID width. When it claims, it drives the status/ID on the low data lanes of its width and pulls the transfer acknowledge low. In every other case it passes the falling edge on to its chain output. A parameter selects how the request is dropped. One policy drops it when the acknowledge read finishes. The other keeps it through the acknowledge and drops it only when a local register access ends.

The controller has three states. `ST_IDLE` waits for a chain falling edge. `ST_CLAIM` drives data and the acknowledge. `ST_PASS` holds the chain output low. Three transitions leave `ST_IDLE` or return to it:
- `ST_IDLE`→`ST_CLAIM` on a falling edge when the claim condition holds.
- `ST_IDLE`→`ST_PASS` on a falling edge when it does not.
- `ST_CLAIM`→`ST_IDLE` when both strobes are high, and `ST_PASS`→`ST_IDLE` when the chain input is high.

Top module: `irq_chain_responder`

## Requirements
- R1: While reset is held and right after it, `irq_n`, `iack_out_n` and `dtack_n` are 1 and `data_oe` is all zero.
- R2: A one-cycle pulse on `req_set` drives `irq_n` low on the following cycle, and it stays low until a release event.
- R3: Take a clock edge where `iack_in_n` is first seen low after being high. If at that edge the request is pending, `addr_lvl` equals `LEVEL` and the width test passes, then from the next cycle `dtack_n` is 0, `data_out[ID_W-1:0]` equals `status_id` and `iack_out_n` stays 1.
- R4: When `addr_lvl` differs from `LEVEL` at that edge, `iack_out_n` goes low on the next cycle and `dtack_n` stays 1. `dtack_n` and `iack_out_n` are never low together.
- R5: When no request is pending at that edge, the edge is passed on in the same way as in R4.
- R6: Requested width is 8 bits when `ds1_n`=1. It is 16 bits when `ds1_n`=0 and `lword_n`=1. It is 32 bits when both are 0. A responder whose width exceeds the requested width passes the edge. A wider request is answered at the responder's own width: `data_oe` is set only on bits below `ID_W`, and `data_out` is 0 above them.
- R7: The request is sampled only at the chain falling edge. A request that arrives during a passed cycle leaves `iack_out_n` low and `dtack_n` high until `iack_in_n` returns high.
- R8: One cycle after both `ds0_n` and `ds1_n` are high in a claimed cycle, `dtack_n` is 1 and `data_oe` is zero. One cycle after `iack_in_n` is high in a passed cycle, `iack_out_n` is 1.
- R9: With `RELEASE_ON_ACK`=1, `irq_n` stays low throughout the claimed cycle. It goes high in the same cycle that `dtack_n` is released.
- R10: With `RELEASE_ON_ACK`=0, `irq_n` stays low through and after the acknowledge, and while `reg_acc` is high. It goes high one cycle after `reg_acc` falls.
- R11: An 8-bit responder claims even when the requested width is 8 bits. It drives only `data_oe`[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 1 | One-cycle pulse that raises a local request |
| reg_acc | input | 1 | High during a local register access; its falling edge releases the request when `RELEASE_ON_ACK`=0 |
| status_id | input | ID_W | Status/ID value returned on a claim |
| iack_in_n | input | 1 | Chain acknowledge input, active low |
| addr_lvl | input | 3 | Level being acknowledged (address bits 1 to 3) |
| ds0_n | input | 1 | Lower data strobe, active low |
| ds1_n | input | 1 | Upper data strobe, active low |
| lword_n | input | 1 | Long-word select, active low |
| irq_n | output | 1 | Interrupt request, active low |
| iack_out_n | output | 1 | Chain acknowledge output, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| data_out | output | BUS_W | Status/ID data value |
| data_oe | output | BUS_W | Per-bit drive enable for `data_out` |

## Verification
The bench raises a chain edge while the level is wrong, while the requested width is too narrow, and while nothing is pending. A design with a loose claim test would pull the acknowledge low on a bus it does not own, alongside the rightful responder. It also sends a 32-bit read to a 16-bit responder and an 8-bit read to an 8-bit responder. A wrong width mask would drive, or pull low, upper lanes that belong to nobody. It then raises a request in the middle of a passed cycle. A design that samples the request continuously would break the chain and claim late. Finally it checks both release policies. A release-on-acknowledge design must not drop the line before the strobes rise. A register-access design must hold the line across the acknowledge and until the access ends, or the handler would see a phantom request or lose a real one.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLAIM = 2'd1,
        ST_PASS  = 2'd2
    } chain_st_t;

    // True when the width asked for by the strobes covers the responder's own width.
    function automatic logic width_ok(input int id_w, input logic ds1_n, input logic lword_n);
        if (id_w <= 8)
            return 1'b1;
        else if (id_w <= 16)
            return !ds1_n;
        else
            return !ds1_n && !lword_n;
    endfunction

endpackage

// File: rtl/irq_req_hold.sv
module irq_req_hold #(
    parameter bit RELEASE_ON_ACK = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic ack_done,
    input  logic reg_acc,
    output logic pend
);
    logic reg_acc_q;
    logic reg_fall;
    logic release_ev;

    assign reg_fall   = reg_acc_q && !reg_acc;
    assign release_ev = RELEASE_ON_ACK ? ack_done : reg_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_acc_q <= 1'b0;
            pend      <= 1'b0;
        end else begin
            reg_acc_q <= reg_acc;
            // a new event wins over a release in the same cycle
            pend      <= req_set || (pend && !release_ev);
        end
    end
endmodule

// File: rtl/irq_chain_fsm.sv
module irq_chain_fsm
    import irq_chain_pkg::*;
#(
    parameter int LEVEL = 3,
    parameter int ID_W  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pend,
    input  logic       iack_in_n,
    input  logic [2:0] addr_lvl,
    input  logic       ds0_n,
    input  logic       ds1_n,
    input  logic       lword_n,
    output logic       iack_out_n,
    output logic       dtack_n,
    output logic       drive_en,
    output logic       ack_done
);
    localparam logic [2:0] MY_LVL = 3'(LEVEL);

    chain_st_t state, state_nx;
    logic      iack_q;
    logic      iack_fall;
    logic      claim_ok;

    assign iack_fall = iack_q && !iack_in_n;
    assign claim_ok  = pend && (addr_lvl == MY_LVL) && width_ok(ID_W, ds1_n, lword_n);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            iack_q <= 1'b1;
        end else begin
            state  <= state_nx;
            iack_q <= iack_in_n;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (iack_fall) state_nx = claim_ok ? ST_CLAIM : ST_PASS;
            ST_CLAIM: if (ds0_n && ds1_n) state_nx = ST_IDLE;
            ST_PASS:  if (iack_in_n) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        iack_out_n = 1'b1;
        dtack_n    = 1'b1;
        drive_en   = 1'b0;
        ack_done   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_CLAIM: begin
                dtack_n  = 1'b0;
                drive_en = 1'b1;
                ack_done = ds0_n && ds1_n;
            end
            ST_PASS:  iack_out_n = 1'b0;
            default:  ;
        endcase
    end
endmodule

// File: rtl/irq_id_drive.sv
module irq_id_drive #(
    parameter int ID_W  = 16,
    parameter int BUS_W = 32
) (
    input  logic             en,
    input  logic [ID_W-1:0]  status_id,
    output logic [BUS_W-1:0] data_out,
    output logic [BUS_W-1:0] data_oe
);
    for (genvar i = 0; i < BUS_W; i++) begin : g_lane
        if (i < ID_W) begin : g_own
            assign data_out[i] = en && status_id[i];
            assign data_oe[i]  = en;
        end else begin : g_idle
            assign data_out[i] = 1'b0;
            assign data_oe[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/irq_chain_responder.sv
module irq_chain_responder #(
    parameter int LEVEL          = 3,
    parameter int ID_W           = 16,
    parameter int BUS_W          = 32,
    parameter bit RELEASE_ON_ACK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_set,
    input  logic             reg_acc,
    input  logic [ID_W-1:0]  status_id,
    input  logic             iack_in_n,
    input  logic [2:0]       addr_lvl,
    input  logic             ds0_n,
    input  logic             ds1_n,
    input  logic             lword_n,
    output logic             irq_n,
    output logic             iack_out_n,
    output logic             dtack_n,
    output logic [BUS_W-1:0] data_out,
    output logic [BUS_W-1:0] data_oe
);
    logic pend;
    logic ack_done;
    logic drive_en;

    irq_req_hold #(.RELEASE_ON_ACK(RELEASE_ON_ACK)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_set  (req_set),
        .ack_done (ack_done),
        .reg_acc  (reg_acc),
        .pend     (pend)
    );

    irq_chain_fsm #(.LEVEL(LEVEL), .ID_W(ID_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend),
        .iack_in_n  (iack_in_n),
        .addr_lvl   (addr_lvl),
        .ds0_n      (ds0_n),
        .ds1_n      (ds1_n),
        .lword_n    (lword_n),
        .iack_out_n (iack_out_n),
        .dtack_n    (dtack_n),
        .drive_en   (drive_en),
        .ack_done   (ack_done)
    );

    irq_id_drive #(.ID_W(ID_W), .BUS_W(BUS_W)) u_drv (
        .en        (drive_en),
        .status_id (status_id),
        .data_out  (data_out),
        .data_oe   (data_oe)
    );

    assign irq_n = !pend;
endmodule

// File: rtl/irq_chain_responder_chk.sv
module irq_chain_responder_chk
    import irq_chain_pkg::*;
#(
    parameter int LEVEL          = 3,
    parameter int ID_W           = 16,
    parameter int BUS_W          = 32,
    parameter bit RELEASE_ON_ACK = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_acc,
    input logic             iack_in_n,
    input logic [2:0]       addr_lvl,
    input logic             ds0_n,
    input logic             ds1_n,
    input logic             lword_n,
    input logic             irq_n,
    input logic             iack_out_n,
    input logic             dtack_n,
    input logic [BUS_W-1:0] data_oe
);
    // R3: a claim starts only for our level with a request pending
    a_r3_claim_level: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> ($past(addr_lvl) == 3'(LEVEL) && !$past(irq_n)));

    // R4: never claim and pass at once
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dtack_n && !iack_out_n));

    // R4: the chain output is low only after the chain input was low
    a_r4_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_out_n |-> !$past(iack_in_n));

    // R6: a claim needs a wide enough request
    a_r6_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(width_ok(ID_W, ds1_n, lword_n)));

    // R8: data lanes are enabled only with the acknowledge
    a_r8_oe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe != '0) |-> !dtack_n);

    // R9 / R10: the request drops only at the policy's release point
    a_r9_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> (RELEASE_ON_ACK ? ($past(!dtack_n && ds0_n && ds1_n))
                                         : ($past(!reg_acc) && $past(reg_acc, 2))));

    // R9: request held while claimed
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !(ds0_n && ds1_n)) |=> !irq_n);
endmodule

bind irq_chain_responder irq_chain_responder_chk #(
    .LEVEL(LEVEL), .ID_W(ID_W), .BUS_W(BUS_W), .RELEASE_ON_ACK(RELEASE_ON_ACK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_acc    (reg_acc),
    .iack_in_n  (iack_in_n),
    .addr_lvl   (addr_lvl),
    .ds0_n      (ds0_n),
    .ds1_n      (ds1_n),
    .lword_n    (lword_n),
    .irq_n      (irq_n),
    .iack_out_n (iack_out_n),
    .dtack_n    (dtack_n),
    .data_oe    (data_oe)
);

// File: tb/irq_chain_responder_tb.sv
`timescale 1ns/1ps
module irq_chain_responder_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_a = 1'b0, set_b = 1'b0, acc_a = 1'b0, acc_b = 1'b0;
    logic iack_in_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, lword_n = 1'b1;
    logic [2:0] addr = 3'd0;
    logic irq_a, iko_a, dtk_a, irq_b, iko_b, dtk_b;
    logic [31:0] dout_a, doe_a, dout_b, doe_b;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_chain_responder #(.LEVEL(3), .ID_W(16), .BUS_W(32), .RELEASE_ON_ACK(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_set(set_a), .reg_acc(acc_a), .status_id(16'hA5C3),
        .iack_in_n(iack_in_n), .addr_lvl(addr), .ds0_n(ds0_n), .ds1_n(ds1_n), .lword_n(lword_n),
        .irq_n(irq_a), .iack_out_n(iko_a), .dtack_n(dtk_a), .data_out(dout_a), .data_oe(doe_a));

    irq_chain_responder #(.LEVEL(5), .ID_W(8), .BUS_W(32), .RELEASE_ON_ACK(1'b0)) u_rora (
        .clk(clk), .rst_n(rst_n), .req_set(set_b), .reg_acc(acc_b), .status_id(8'h7E),
        .iack_in_n(iack_in_n), .addr_lvl(addr), .ds0_n(ds0_n), .ds1_n(ds1_n), .lword_n(lword_n),
        .irq_n(irq_b), .iack_out_n(iko_b), .dtack_n(dtk_b), .data_out(dout_b), .data_oe(doe_b));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ack_start(input logic [2:0] lvl, input logic s1, input logic lw);
        addr = lvl; ds0_n = 1'b0; ds1_n = s1; lword_n = lw;
        step();
        iack_in_n = 1'b0;
        step();
    endtask

    task automatic strobes_up();
        ds0_n = 1'b1; ds1_n = 1'b1; lword_n = 1'b1;
        step();
    endtask

    task automatic iack_up();
        iack_in_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        check("R1 irq_n", irq_a, 1);
        check("R1 iack_out_n", iko_a, 1);
        check("R1 dtack_n", dtk_a, 1);
        check("R1 data_oe", doe_a, 0);
    endtask

    task automatic t_no_pending();
        ack_start(3'd3, 1'b0, 1'b0);
        check("R5 pass iack_out_n", iko_a, 0);
        check("R5 no dtack", dtk_a, 1);
        strobes_up();
        check("R5 still passing", iko_a, 0);
        iack_up();
        check("R8 iack_out_n back high", iko_a, 1);
    endtask

    task automatic t_request();
        set_a = 1'b1; step(); set_a = 1'b0;
        check("R2 irq_n low", irq_a, 0);
        repeat (3) step();
        check("R2 irq_n held", irq_a, 0);
    endtask

    task automatic t_mismatch();
        ack_start(3'd2, 1'b0, 1'b0);
        check("R4 pass on level mismatch", iko_a, 0);
        check("R4 no dtack", dtk_a, 1);
        strobes_up(); iack_up();
        check("R4 request kept", irq_a, 0);
    endtask

    task automatic t_narrow();
        ack_start(3'd3, 1'b1, 1'b1);
        check("R6 narrow request passed", iko_a, 0);
        check("R6 narrow no dtack", dtk_a, 1);
        strobes_up(); iack_up();
    endtask

    task automatic t_claim();
        ack_start(3'd3, 1'b0, 1'b0);
        check("R3 dtack_n low", dtk_a, 0);
        check("R3 R6 data_out", dout_a, 32'h0000A5C3);
        check("R6 data_oe own width", doe_a, 32'h0000FFFF);
        check("R3 chain held", iko_a, 1);
        check("R9 irq held in claim", irq_a, 0);
        check("R4 other level passes", iko_b, 0);
        strobes_up();
        check("R8 dtack released", dtk_a, 1);
        check("R8 data_oe released", doe_a, 0);
        check("R9 irq released", irq_a, 1);
        iack_up();
    endtask

    task automatic t_late();
        ack_start(3'd3, 1'b0, 1'b0);
        check("R7 pass without request", iko_a, 0);
        set_a = 1'b1; step(); set_a = 1'b0; step();
        check("R7 still passing", iko_a, 0);
        check("R7 no late claim", dtk_a, 1);
        check("R7 request now pending", irq_a, 0);
        strobes_up(); iack_up();
        check("R8 chain back high", iko_a, 1);
    endtask

    task automatic t_rora();
        set_b = 1'b1; step(); set_b = 1'b0;
        ack_start(3'd5, 1'b1, 1'b1);
        check("R11 8-bit claim dtack", dtk_b, 0);
        check("R11 data_out", dout_b, 32'h0000007E);
        check("R11 data_oe", doe_b, 32'h000000FF);
        check("R10 irq held in ack", irq_b, 0);
        strobes_up();
        check("R8 dtack_b released", dtk_b, 1);
        check("R10 irq kept after ack", irq_b, 0);
        iack_up();
        acc_b = 1'b1; step(); step();
        check("R10 irq kept during access", irq_b, 0);
        acc_b = 1'b0; step();
        check("R10 irq released after access", irq_b, 1);
    endtask

    initial begin
        repeat (4) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_no_pending();
        t_request();
        t_mismatch();
        t_narrow();
        t_claim();
        t_late();
        t_rora();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule